// File: doc/BRIEF.md
# Pin Edge Capture Interrupt Unit

This unit samples a bank of 28 asynchronous input pins, finds transitions on them, and keeps each enabled transition as a sticky pending flag. Every pin has two enable bits, one for low-to-high and one for high-to-low. Setting both captures either transition. Clearing both masks the pin, so no new transition on it is recorded.

Software reads the flags and clears them by writing ones over a small register port. The first 11 pins each drive a private interrupt wire. The remaining 17 pins share a single wire, which is high while any of their flags is pending. Each pin passes through a two-stage synchroniser. A transition is the difference between two successive synchronised samples.

Register map (word address on `reg_addr`):
- 0 holds the low-to-high enables.
- 1 holds the high-to-low enables.
- 2 holds the pending flags.
- 3 reads zero.

Bit i of each register belongs to pin i.

Top module: `gpio_edge_irq`

## Requirements
- R1: With only the low-to-high enable of a pin set (address 0, bit i), a 0-to-1 transition sets pending bit i (address 2), and a 1-to-0 transition does not.
- R2: With only the high-to-low enable set (address 1, bit i), a 1-to-0 transition sets pending bit i, and a 0-to-1 transition does not.
- R3: With both enables of a pin set, a transition in either direction sets its pending bit.
- R4: A write to address 2 clears each pending bit whose data bit is one. Bits written with zero keep their value. Pending bits otherwise stay set.
- R5: Writing all ones to address 2 clears every pending bit in one write.
- R6: Output `irq_pin[i]` for i in 0..10 equals pending bit i.
- R7: Output `irq_shared` is high exactly when any of pending bits 11..27 is set.
- R8: A pin whose two enables are both zero never gets its pending bit set by a transition.
- R9: After reset, both enable registers and all pending bits read zero, and all interrupt outputs are low.
- R10: If a transition is latched in the same cycle as a clearing write to that bit, the bit remains set.
- R11: Bits 31..28 of addresses 0, 1 and 2 read zero and ignore writes. Address 3 reads zero.
- R12: A pin change just after a clock edge sets the pending bit on the third following rising clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 28 | Asynchronous pin levels |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pin | output | 11 | Private interrupt wires of pins 0..10 |
| irq_shared | output | 1 | Shared interrupt wire of pins 11..27 |

## Verification
A table of vectors sets enable patterns and drives a pin bank from one level pattern to another. The patterns include all-rise, all-fall, both, split halves, masked, and the two end pins. Together they separate low-to-high from high-to-low capture and show that masking holds. Each vector also checks which private and shared wires follow the result. Directed tests cover the reset state, partial and full clearing, a clear that collides with a fresh transition, the unused upper bits, and the three-edge capture latency.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 28,
  parameter int NDEDI = 11,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [NDEDI-1:0] irq_pin,
  output logic             irq_shared
);
  localparam logic [AW-1:0] A_RISE = AW'(0);
  localparam logic [AW-1:0] A_FALL = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] rise_en, fall_en, status;
  logic [NPINS-1:0] hit, clr;

  assign hit = (sync2 & ~prev & rise_en) | (~sync2 & prev & fall_en);
  assign clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      sync1  <= pins_in;
      sync2  <= sync1;
      prev   <= sync2;
      status <= (status & ~clr) | hit;
      if (reg_wr && reg_addr == A_RISE) rise_en <= reg_wdata[NPINS-1:0];
      if (reg_wr && reg_addr == A_FALL) fall_en <= reg_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RISE:  reg_rdata[NPINS-1:0] = rise_en;
      A_FALL:  reg_rdata[NPINS-1:0] = fall_en;
      A_STAT:  reg_rdata[NPINS-1:0] = status;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_pin    = status[NDEDI-1:0];
  assign irq_shared = |status[NPINS-1:NDEDI];

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(hit)) == '0 &&
    ((~status & $past(status)) & ~$past(clr)) == '0);

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & $past(clr)) & ~status) == '0);

  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0);

  p_full_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[NPINS-1:0] == '1 && hit == '0)
    |=> status == '0);
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins_in = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] irq_pin;
  logic        irq_shared;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: rise_en, fall_en, level before, level after, expected pending
  localparam int NV = 8;
  localparam logic [139:0] VEC [NV] = '{
    {28'hFFFFFFF, 28'h0000000, 28'h0000000, 28'h00000F0, 28'h00000F0},
    {28'hFFFFFFF, 28'h0000000, 28'hFFFFFFF, 28'hFFFFF0F, 28'h0000000},
    {28'h0000000, 28'hFFFFFFF, 28'hFFFFFFF, 28'hFFFF0FF, 28'h0000F00},
    {28'h0000000, 28'hFFFFFFF, 28'h0000000, 28'h5555555, 28'h0000000},
    {28'hFFFFFFF, 28'hFFFFFFF, 28'hAAAAAAA, 28'h5555555, 28'hFFFFFFF},
    {28'h000FFFF, 28'hFFF0000, 28'h0000000, 28'hFFFFFFF, 28'h000FFFF},
    {28'h0000000, 28'h0000000, 28'h0000000, 28'hFFFFFFF, 28'h0000000},
    {28'h8000001, 28'h0000000, 28'h0000000, 28'hFFFFFFF, 28'h8000001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(2'd0, d); check("R9 rise enables", d, 32'h0);
    rd(2'd1, d); check("R9 fall enables", d, 32'h0);
    rd(2'd2, d); check("R9 pending", d, 32'h0);
    check("R9 irq lines", {20'h0, irq_shared, irq_pin}, 32'h0);

    // table: R1 R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [27:0] re, fe, la, lb, ex;
      {re, fe, la, lb, ex} = VEC[i];
      wr(2'd0, {4'h0, 28'h0});
      wr(2'd1, {4'h0, 28'h0});
      pins_in = la;
      settle();
      wr(2'd2, 32'hFFFFFFFF);
      wr(2'd0, {4'h0, re});
      wr(2'd1, {4'h0, fe});
      @(negedge clk);
      pins_in = lb;
      settle();
      rd(2'd2, d);
      check($sformatf("R1/R2/R3/R8 vector %0d pending", i), d, {4'h0, ex});
      check($sformatf("R6 vector %0d private lines", i), {21'h0, irq_pin}, {21'h0, ex[10:0]});
      check($sformatf("R7 vector %0d shared line", i), {31'h0, irq_shared}, {31'h0, |ex[27:11]});
    end

    // R4 partial clear
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    pins_in = '0; settle();
    wr(2'd2, 32'hFFFFFFFF);
    wr(2'd0, {4'h0, 28'hFFFFFFF});
    pins_in = 28'h0F0F00F; settle();
    wr(2'd2, 32'h0);
    rd(2'd2, d); check("R4 zero write keeps", d, 32'h0F0F00F);
    wr(2'd2, 32'h0000003);
    rd(2'd2, d); check("R4 one clears selected", d, 32'h0F0F00C);
    check("R6 after partial clear", {21'h0, irq_pin}, {21'h0, 11'h00C});
    wr(2'd2, 32'h0F0F000);
    rd(2'd2, d); check("R4 upper bits cleared", d, 32'h000000C);
    check("R7 shared low when 11..27 clear", {31'h0, irq_shared}, 32'h0);
    // R5 full clear
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, d); check("R5 all ones clears", d, 32'h0);

    // R12 latency
    @(negedge clk); pins_in[3] = 1'b0; settle();
    wr(2'd2, 32'hFFFFFFFF);
    @(negedge clk); pins_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(2'd2, d); check("R12 not set after two edges", d, 32'h0);
    @(negedge clk); rd(2'd2, d); check("R12 set on third edge", d, 32'h0000020);

    // R10 clear collides with fresh edge on bit 5
    wr(2'd1, {4'h0, 28'hFFFFFFF});
    @(negedge clk); pins_in[5] = 1'b0;
    @(negedge clk);
    wr(2'd2, 32'h0000020);
    rd(2'd2, d); check("R10 edge wins over clear", d, 32'h0000020);
    wr(2'd2, 32'h0000020);
    rd(2'd2, d); check("R4 later clear works", d, 32'h0);

    // R11 upper bits
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, d); check("R11 rise enable upper zero", d, 32'h0FFFFFFF);
    wr(2'd1, 32'hF0000000);
    rd(2'd1, d); check("R11 fall enable upper zero", d, 32'h0);
    rd(2'd3, d); check("R11 address 3 zero", d, 32'h0);
    rd(2'd2, d); check("R11 pending upper zero", d, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule